// File: doc/BRIEF.md
# NAND Bad Block Scanner

This block sweeps one die of a NAND array and builds a compact list of its defective blocks. When started, it visits each block of the die in ascending order and issues a read request for the first page of that block to an external page-read engine. It keeps only two words from each returned page: the leading data word and the leading spare word. A block whose two marker words are not both in the erased all-ones state is counted as bad. Its in-die block number is written into the next free slot of a bad-block table through a simple write port.

At the end of the sweep the block raises a one-cycle completion pulse. At that point it presents the number of table entries written and a flag that records whether bad blocks were found after the table was already full. The controller runs as a five-state machine. The states are:

- IDLE: waits for start. The transition IDLE→ISSUE happens on start and latches the die.
- ISSUE: raises the read request for one cycle, then moves ISSUE→WAIT.
- WAIT: holds until the read completes. The transition WAIT→EVAL happens on read completion and captures the marker words.
- EVAL: judges the block and writes the table. It moves EVAL→ISSUE while blocks remain, and EVAL→FINISH after the last block.
- FINISH: signals completion and always moves FINISH→IDLE.

Top module: `badblk_scanner`

## Requirements
- R1: In IDLE, a start pulse begins a sweep of the die given by `die_idx`, which is latched at that moment. A start pulse while a sweep is running is ignored, and the running sweep keeps its die.
- R2: Blocks per die equals PLANES_PER_DIE × BLKS_PER_PLANE. Blocks are read in order 0, 1, …, blocks-per-die − 1. The read for block b of die d carries row address (b + blocks_per_die × d) × PAGES_PER_BLOCK.
- R3: A block is bad when its captured data word differs from 32'hFFFFFFFF or its captured spare word differs from 32'hFFFFFFFF. A single clear bit in either word is enough.
- R4: Each bad block is written with `tbl_we` high for one cycle. `tbl_entry` carries the block number within the die, not the global number. `tbl_idx` takes the values 0, 1, 2, … in the order the bad blocks are found.
- R5: `bad_count` equals the number of table entries written in the current sweep. It is cleared when a new sweep is accepted.
- R6: Only one read is outstanding at a time. `rd_req` is high for exactly one cycle, and no further request is issued until `rd_done` returns. An `rd_done` arriving while no read is pending has no effect.
- R7: Once TBL_DEPTH entries have been written, further bad blocks produce no write. Instead they set `overflow`, and `bad_count` stays at TBL_DEPTH. `overflow` stays high until the next sweep is accepted.
- R8: `done` is high for exactly one cycle, in the cycle after the last block is evaluated. `busy` is high from the cycle after start is accepted up to and including the `done` cycle.
- R9: After reset, `rd_req`, `tbl_we`, `done`, `busy`, `overflow` and `bad_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (accepted in IDLE only) |
| die_idx | input | DIE_W | Die to be swept |
| rd_req | output | 1 | One-cycle page read request |
| rd_row | output | ROW_W | Row address of the requested page |
| rd_done | input | 1 | Read completion strobe |
| rd_data0 | input | 32 | First data word of the returned page |
| rd_spare0 | input | 32 | First spare word of the returned page |
| tbl_we | output | 1 | Table write enable |
| tbl_idx | output | clog2(TBL_DEPTH) | Table slot being written |
| tbl_entry | output | clog2(blocks per die) | In-die block number being written |
| bad_count | output | clog2(TBL_DEPTH+1) | Entries written in this sweep |
| overflow | output | 1 | A bad block was found with the table full |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle sweep completion pulse |

## Verification
The hardest situation to reach is a bad block arriving when the table is already full. To get there, the bench runs a sweep in which every block is bad in its data word. It then checks that exactly TBL_DEPTH writes appear, that the count saturates, and that `overflow` rises. The next sweep checks that `overflow` has cleared. Timing-sensitive cases get directed stimulus: a start pulse in the middle of a sweep with a different die, and a stray `rd_done` while idle. Read latency is varied between sweeps so that the WAIT state is held for different lengths. After every completion strobe the bench drives corrupted marker words, so a capture taken in the wrong cycle would be caught.

// File: rtl/badblk_pkg.sv
package badblk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_EVAL,
        S_FINISH
    } scan_state_t;

    function automatic int clog2_min1(input int value);
        return (value > 1) ? $clog2(value) : 1;
    endfunction

endpackage

// File: rtl/badblk_rowcalc.sv
module badblk_rowcalc #(
    parameter int BLOCKS_PER_DIE  = 16,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLK_W           = 4,
    parameter int DIE_W           = 2,
    parameter int ROW_W           = 24
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [DIE_W-1:0] die,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] BPD = ROW_W'(BLOCKS_PER_DIE);
    localparam logic [ROW_W-1:0] PPB = ROW_W'(PAGES_PER_BLOCK);

    always_comb begin
        row = (ROW_W'(blk) + ROW_W'(die) * BPD) * PPB;
    end
endmodule

// File: rtl/badblk_marker.sv
module badblk_marker #(
    parameter int NUM_MARK = 2,
    parameter int WORD_W   = 32
) (
    input  logic [NUM_MARK-1:0][WORD_W-1:0] words,
    output logic                            is_bad
);
    logic [NUM_MARK-1:0] not_erased;

    for (genvar g = 0; g < NUM_MARK; g++) begin : g_mark
        assign not_erased[g] = (words[g] != {WORD_W{1'b1}});
    end

    assign is_bad = |not_erased;
endmodule

// File: rtl/badblk_compact.sv
module badblk_compact #(
    parameter int TBL_DEPTH = 8,
    parameter int BLK_W     = 4,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             eval,
    input  logic             bad,
    input  logic [BLK_W-1:0] blk,
    output logic             we,
    output logic [IDX_W-1:0] idx,
    output logic [BLK_W-1:0] entry,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TBL_DEPTH);

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             has_room;

    assign has_room = (count_q < FULL);
    assign we       = eval && bad && has_room;
    assign idx      = IDX_W'(count_q);
    assign entry    = blk;
    assign count    = count_q;
    assign overflow = ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (clear) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (eval && bad) begin
            if (has_room) count_q <= count_q + 1'b1;
            else          ovf_q   <= 1'b1;
        end
    end

    // R7: the count never passes the table capacity
    a_r7_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);
endmodule

// File: rtl/badblk_scanner.sv
module badblk_scanner
    import badblk_pkg::*;
#(
    parameter int PLANES_PER_DIE  = 2,
    parameter int BLKS_PER_PLANE  = 8,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int DIE_W           = 2,
    parameter int ROW_W           = 24,
    parameter int TBL_DEPTH       = 8
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   start,
    input  logic [DIE_W-1:0]                                       die_idx,
    output logic                                                   rd_req,
    output logic [ROW_W-1:0]                                       rd_row,
    input  logic                                                   rd_done,
    input  logic [31:0]                                            rd_data0,
    input  logic [31:0]                                            rd_spare0,
    output logic                                                   tbl_we,
    output logic [clog2_min1(TBL_DEPTH)-1:0]                       tbl_idx,
    output logic [clog2_min1(PLANES_PER_DIE*BLKS_PER_PLANE)-1:0]   tbl_entry,
    output logic [$clog2(TBL_DEPTH+1)-1:0]                         bad_count,
    output logic                                                   overflow,
    output logic                                                   busy,
    output logic                                                   done
);
    localparam int BLOCKS_PER_DIE = PLANES_PER_DIE * BLKS_PER_PLANE;
    localparam int BLK_W          = clog2_min1(BLOCKS_PER_DIE);
    localparam int IDX_W          = clog2_min1(TBL_DEPTH);
    localparam int CNT_W          = $clog2(TBL_DEPTH + 1);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS_PER_DIE - 1);

    scan_state_t state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic [DIE_W-1:0] die_q;
    logic [1:0][31:0] marks_q;
    logic             blk_bad;
    logic             eval;
    logic             clear;
    logic             last_blk;

    assign last_blk = (blk_q == LAST_BLK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)   state_d = S_ISSUE;
            S_ISSUE:               state_d = S_WAIT;
            S_WAIT:   if (rd_done) state_d = S_EVAL;
            S_EVAL:   state_d = last_blk ? S_FINISH : S_ISSUE;
            S_FINISH:              state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        rd_req = 1'b0;
        eval   = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        clear  = 1'b0;
        unique case (state_q)
            S_IDLE:   begin busy = 1'b0; clear = start; end
            S_ISSUE:  rd_req = 1'b1;
            S_WAIT:   ;
            S_EVAL:   eval = 1'b1;
            S_FINISH: done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q   <= '0;
            die_q   <= '0;
            marks_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                blk_q <= '0;
                die_q <= die_idx;
            end
            if (state_q == S_WAIT && rd_done) begin
                marks_q <= {rd_spare0, rd_data0};
            end
            if (state_q == S_EVAL && !last_blk) begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

    badblk_rowcalc #(
        .BLOCKS_PER_DIE (BLOCKS_PER_DIE),
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .BLK_W          (BLK_W),
        .DIE_W          (DIE_W),
        .ROW_W          (ROW_W)
    ) u_rowcalc (
        .blk(blk_q),
        .die(die_q),
        .row(rd_row)
    );

    badblk_marker #(
        .NUM_MARK(2),
        .WORD_W  (32)
    ) u_marker (
        .words (marks_q),
        .is_bad(blk_bad)
    );

    badblk_compact #(
        .TBL_DEPTH(TBL_DEPTH),
        .BLK_W    (BLK_W),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_compact (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .eval    (eval),
        .bad     (blk_bad),
        .blk     (blk_q),
        .we      (tbl_we),
        .idx     (tbl_idx),
        .entry   (tbl_entry),
        .count   (bad_count),
        .overflow(overflow)
    );

    // R6: a request lasts one cycle
    a_r6_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R6: the machine holds in WAIT until the read returns
    a_r6_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !rd_done) |=> (state_q == S_WAIT && !rd_req));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: every table write advances the count by one
    a_r4_dense_fill: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> (bad_count == $past(bad_count) + 1'b1));

    // R7: overflow is held for the rest of the sweep
    a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && busy) |=> overflow);
endmodule

// File: tb/badblk_scanner_test.sv
`timescale 1ns/1ps
module badblk_scanner_test;
    localparam int PLANES = 2;
    localparam int BPP    = 8;
    localparam int PAGES  = 64;
    localparam int DIE_W  = 2;
    localparam int ROW_W  = 24;
    localparam int DEPTH  = 8;
    localparam int NBLK   = PLANES * BPP;
    localparam int NVEC   = 6;

    // vector layout: {die[1:0], data_bad_mask[15:0], spare_bad_mask[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 16'h0000, 16'h0000},
        {2'd1, 16'h0001, 16'h8000},
        {2'd2, 16'h00F0, 16'h0F00},
        {2'd3, 16'hFFFF, 16'h0000},
        {2'd0, 16'h0000, 16'h2424},
        {2'd1, 16'h1111, 16'h1010}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [DIE_W-1:0] die_idx;
    logic             rd_req;
    logic [ROW_W-1:0] rd_row;
    logic             rd_done;
    logic [31:0]      rd_data0;
    logic [31:0]      rd_spare0;
    logic             tbl_we;
    logic [2:0]       tbl_idx;
    logic [3:0]       tbl_entry;
    logic [3:0]       bad_count;
    logic             overflow;
    logic             busy;
    logic             done;

    always #4 clk = ~clk;

    badblk_scanner #(
        .PLANES_PER_DIE (PLANES),
        .BLKS_PER_PLANE (BPP),
        .PAGES_PER_BLOCK(PAGES),
        .DIE_W          (DIE_W),
        .ROW_W          (ROW_W),
        .TBL_DEPTH      (DEPTH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .die_idx(die_idx),
        .rd_req(rd_req), .rd_row(rd_row), .rd_done(rd_done),
        .rd_data0(rd_data0), .rd_spare0(rd_spare0),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_entry(tbl_entry),
        .bad_count(bad_count), .overflow(overflow), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    logic [15:0] dmask, smask;
    logic [1:0]  sdie;
    int          lat = 1;
    int          exp_list [NBLK];
    int          n_bad;
    int          rd_seen;
    int          wr_seen;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // page-read engine model
    initial begin
        rd_done = 1'b0; rd_data0 = '0; rd_spare0 = '0;
        forever begin
            @(negedge clk);
            if (rd_req) begin
                int b;
                b = rd_seen;
                chk(rd_row == ROW_W'((b + NBLK * int'(sdie)) * PAGES),
                    "R2 row address", rd_row, (b + NBLK * int'(sdie)) * PAGES);
                rd_seen++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    chk(!rd_req, "R6 no second request while pending", rd_req, 0);
                end
                rd_data0  = dmask[b] ? ~(32'h1 << b) : 32'hFFFF_FFFF;
                rd_spare0 = smask[b] ? ((b % 2 == 1) ? 32'h7FFF_FFFF : 32'h0) : 32'hFFFF_FFFF;
                rd_done   = 1'b1;
                @(negedge clk);
                rd_done   = 1'b0;
                rd_data0  = 32'h0;
                rd_spare0 = 32'h0;
            end
        end
    end

    // table write monitor
    initial begin
        forever begin
            @(negedge clk);
            if (tbl_we) begin
                chk(wr_seen < n_bad && wr_seen < DEPTH, "R7 write only within capacity", wr_seen, DEPTH);
                chk(tbl_idx == 3'(wr_seen), "R4 table index", tbl_idx, wr_seen);
                if (wr_seen < NBLK)
                    chk(int'(tbl_entry) == exp_list[wr_seen], "R4 R3 table entry", tbl_entry, exp_list[wr_seen]);
                wr_seen++;
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        finish_run();
    end

    task automatic setup(input logic [1:0] d, input logic [15:0] dm, input logic [15:0] sm, input int l);
        sdie = d; dmask = dm; smask = sm; lat = l;
        n_bad = 0;
        for (int b = 0; b < NBLK; b++) begin
            exp_list[b] = 0;
            if (dm[b] || sm[b]) begin
                exp_list[n_bad] = b;
                n_bad++;
            end
        end
        rd_seen = 0;
        wr_seen = 0;
    endtask

    task automatic wait_and_check();
        int exp_cnt;
        exp_cnt = (n_bad > DEPTH) ? DEPTH : n_bad;
        while (!done) @(negedge clk);
        chk(int'(bad_count) == exp_cnt, "R5 final count", bad_count, exp_cnt);
        chk(overflow == (n_bad > DEPTH), "R7 overflow flag", overflow, n_bad > DEPTH);
        chk(wr_seen == exp_cnt, "R4 number of writes", wr_seen, exp_cnt);
        chk(rd_seen == NBLK, "R2 reads per sweep", rd_seen, NBLK);
        chk(busy, "R8 busy during done", busy, 1);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", done, 0);
        chk(!busy, "R8 idle after done", busy, 0);
    endtask

    task automatic run_scan(input logic [1:0] d, input logic [15:0] dm, input logic [15:0] sm, input int l);
        setup(d, dm, sm, l);
        @(negedge clk);
        start = 1'b1; die_idx = d;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1 sweep accepted", busy, 1);
        wait_and_check();
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; die_idx = '0;
        sdie = '0; dmask = '0; smask = '0; n_bad = 0; rd_seen = 0; wr_seen = 0;
        repeat (3) @(negedge clk);
        chk(!rd_req && !tbl_we && !done && !busy && !overflow && bad_count == 0,
            "R9 reset state", {rd_req, tbl_we, done, busy, overflow, bad_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req, "R9 idle after reset", {busy, rd_req}, 0);

        // table-driven sweeps: clean, edge blocks, exactly full, overflow,
        // overflow clear, overlapping markers
        for (int i = 0; i < NVEC; i++) begin
            run_scan(VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], 1 + (i % 3));
        end

        // R1: start with another die in mid-sweep is ignored
        setup(2'd2, 16'h0402, 16'h0000, 2);
        @(negedge clk);
        start = 1'b1; die_idx = 2'd2;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        start = 1'b1; die_idx = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1 sweep continues after stray start", busy, 1);
        wait_and_check();

        // R6: stray completion while idle has no effect
        @(negedge clk);
        rd_data0 = 32'h0; rd_spare0 = 32'h0; rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!tbl_we && !busy && !rd_req, "R6 stray rd_done ignored", {tbl_we, busy, rd_req}, 0);
            @(negedge clk);
        end
        chk(bad_count == 4'd2, "R6 count unchanged by stray rd_done", bad_count, 2);

        // R3: single-bit markers on the last block only
        run_scan(2'd3, 16'h8000, 16'h0000, 3);

        finish_run();
    end
endmodule